// File: doc/BRIEF.md
# CAN Error Confinement and Bus-Off Recovery

This block keeps the transmit and receive error counters of a CAN controller and decides from them the controller's health. The protocol engine computes how much each counter should rise or fall and delivers that as single-cycle pulses. From the counters the block derives three indications: a warning that either counter has reached a programmable limit, an error-passive flag, and the bus-off state. It raises a warning interrupt pulse whenever the warning or bus-off indication changes.

When the transmit counter would pass 255, the controller goes bus-off and forces itself into reset mode. Once software leaves reset mode, the block uses the transmit counter as a countdown of bus-free periods. A bus-free period is eleven recessive bits in a row, sampled on the bit-rate strobe. After 128 such periods the controller returns to bus-on with clean counters.

Software may load the counters and the warning limit only while reset mode is active. Loading 255 into the transmit counter starts a bus-off. Loading any lower value during bus-off cuts the recovery to a single bus-free period. Status changes that a software load would cause are deferred until reset mode is left.

Top module: `can_fault_confine`

## Requirements
- R1: After reset, `tec` and `rec` read 0, `ewl` reads 96, `rst_mode` is 1, and `err_stat`, `err_passive`, `bus_off`, `ewi` and `bus_idle` are 0.
- R2: Counter pulses take effect only when `rst_mode` is 0 and `bus_off` is 0. A cycle with `tec_up` adds `tec_up_amt`, and `tec_dn` subtracts 1 with a floor of 0; both may occur in the same cycle. `rec` behaves the same way with its own inputs and also saturates at 255.
- R3: Outside reset mode and bus-off, `err_stat` is 1 one cycle after either counter is at or above `ewl`. `err_passive` is 1 one cycle after either counter is at or above 128.
- R4: `ewi` is a one-cycle pulse, issued one cycle after `err_stat` or `bus_off` changes, but only when `ewi_en` is 1. No pulse occurs while `ewi_en` is 0.
- R5: A transmit update whose result would exceed 255 enters bus-off in the same edge. `bus_off` becomes 1, `rst_mode` becomes 1, `tec` becomes 127, `rec` becomes 0, and `err_stat` and `err_passive` become 1.
- R6: While `bus_off` is 1 and `rst_mode` is 0, each run of 11 consecutive recessive samples (`bus_rx`=1 on `bit_stb`) decrements `tec`. A dominant sample restarts the run. The period that completes with `tec` at 0 (the 128th) clears `bus_off`, `err_stat` and `err_passive`, and leaves both counters at 0.
- R7: `wr_tec`, `wr_rec` and `wr_ewl` load `wr_data` only while `rst_mode` is 1. Otherwise they are ignored. `wr_rec` is also ignored while `bus_off` is 1.
- R8: A load of 255 into `tec` outside bus-off enters bus-off, with the effects of R5, one cycle after `rst_mode` is cleared.
- R9: During bus-off, a load of 0 to 254 into `tec` sets it to 0. Bus-on then follows after one bus-free period once `rst_mode` is cleared.
- R10: While `rst_mode` stays 1, `err_stat` and `err_passive` hold their values. A counter loaded by software affects them only after `rst_mode` is cleared.
- R11: `bus_idle` becomes 1 on the 11th consecutive recessive sample and returns to 0 on any dominant sample.
- R12: A cycle with `rm_wr` loads `rm_val` into `rst_mode`, except when a bus-off entry in the same edge forces it to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tec_up | input | 1 | Transmit counter increment pulse |
| tec_up_amt | input | 4 | Increment amount for the transmit counter |
| tec_dn | input | 1 | Transmit counter decrement-by-one pulse |
| rec_up | input | 1 | Receive counter increment pulse |
| rec_up_amt | input | 4 | Increment amount for the receive counter |
| rec_dn | input | 1 | Receive counter decrement-by-one pulse |
| bit_stb | input | 1 | Bit-rate sample strobe |
| bus_rx | input | 1 | Sampled bus level, 1 = recessive |
| rm_wr | input | 1 | Reset-mode control write |
| rm_val | input | 1 | Value for reset mode |
| ewi_en | input | 1 | Warning interrupt enable |
| wr_tec | input | 1 | Software load of the transmit counter |
| wr_rec | input | 1 | Software load of the receive counter |
| wr_ewl | input | 1 | Software load of the warning limit |
| wr_data | input | 8 | Data for software loads |
| rst_mode | output | 1 | Reset mode active |
| err_stat | output | 1 | Warning-level error status |
| err_passive | output | 1 | Error-passive indication |
| bus_off | output | 1 | Bus-off state |
| ewi | output | 1 | Warning interrupt pulse |
| bus_idle | output | 1 | Bus seen idle |
| tec | output | 8 | Transmit error counter |
| rec | output | 8 | Receive error counter |
| ewl | output | 8 | Warning limit |

## Verification
A wrong counter value shows on `tec` or `rec` at the edge that applies the update. A mistaken status derivation shows on `err_stat`, `err_passive` or `ewi` one cycle later. A fault in the recessive-run counter is the slowest to appear: it surfaces only when a bus-free period completes, as a `tec` decrement that arrives a sample early or late, or as `bus_idle` rising at the wrong sample. The bench therefore steps the counters through whole sweeps, and counts recovery periods at the exact sample where each one should complete.

// File: rtl/can_fault_confine.sv
module can_fault_confine #(
  parameter int RUN_LEN     = 11,
  parameter int RECOV_START = 127,
  parameter int WARN_RST    = 96,
  parameter int PASSIVE_LVL = 128,
  parameter int AMT_W       = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tec_up,
  input  logic [AMT_W-1:0] tec_up_amt,
  input  logic             tec_dn,
  input  logic             rec_up,
  input  logic [AMT_W-1:0] rec_up_amt,
  input  logic             rec_dn,
  input  logic             bit_stb,
  input  logic             bus_rx,
  input  logic             rm_wr,
  input  logic             rm_val,
  input  logic             ewi_en,
  input  logic             wr_tec,
  input  logic             wr_rec,
  input  logic             wr_ewl,
  input  logic [7:0]       wr_data,
  output logic             rst_mode,
  output logic             err_stat,
  output logic             err_passive,
  output logic             bus_off,
  output logic             ewi,
  output logic             bus_idle,
  output logic [7:0]       tec,
  output logic [7:0]       rec,
  output logic [7:0]       ewl
);
  localparam int RUN_W = $clog2(RUN_LEN + 1);

  logic [7:0] tec_q, rec_q, ewl_q;
  logic rm_q, bo_q, es_q, ep_q, ewi_q, idle_q, force_q;
  logic es_n, ep_n, bo_n;
  logic [RUN_W-1:0] run_q;
  logic [8:0] tec_add, tec_nx, rec_add, rec_nx;

  wire active     = !rm_q && !bo_q;
  wire period     = bit_stb && bus_rx && (run_q == RUN_W'(RUN_LEN - 1));
  assign tec_add  = 9'(tec_q) + (tec_up ? 9'(tec_up_amt) : 9'd0);
  assign tec_nx   = (tec_dn && tec_add != 9'd0) ? tec_add - 9'd1 : tec_add;
  assign rec_add  = 9'(rec_q) + (rec_up ? 9'(rec_up_amt) : 9'd0);
  assign rec_nx   = (rec_dn && rec_add != 9'd0) ? rec_add - 9'd1 : rec_add;
  wire enter_bo   = active && (tec_nx[8] || force_q);
  wire recov_tick = bo_q && !rm_q && period;
  wire recov_done = recov_tick && (tec_q == 8'd0);

  always_comb begin
    es_n = es_q;
    ep_n = ep_q;
    bo_n = bo_q;
    if (enter_bo) begin
      bo_n = 1'b1; es_n = 1'b1; ep_n = 1'b1;
    end else if (recov_done) begin
      bo_n = 1'b0; es_n = 1'b0; ep_n = 1'b0;
    end else if (active) begin
      es_n = (tec_q >= ewl_q) || (rec_q >= ewl_q);
      ep_n = (32'(tec_q) >= PASSIVE_LVL) || (32'(rec_q) >= PASSIVE_LVL);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      es_q  <= 1'b0;
      ep_q  <= 1'b0;
      bo_q  <= 1'b0;
      ewi_q <= 1'b0;
    end else begin
      es_q  <= es_n;
      ep_q  <= ep_n;
      bo_q  <= bo_n;
      ewi_q <= ewi_en && ((es_n != es_q) || (bo_n != bo_q));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tec_q   <= 8'd0;
      rec_q   <= 8'd0;
      ewl_q   <= 8'(WARN_RST);
      force_q <= 1'b0;
    end else if (enter_bo) begin
      tec_q   <= 8'(RECOV_START);
      rec_q   <= 8'd0;
      force_q <= 1'b0;
    end else if (recov_done) begin
      tec_q <= 8'd0;
      rec_q <= 8'd0;
    end else if (recov_tick) begin
      tec_q <= tec_q - 8'd1;
    end else if (active) begin
      tec_q <= tec_nx[7:0];
      rec_q <= rec_nx[8] ? 8'hFF : rec_nx[7:0];
    end else if (rm_q) begin
      if (wr_tec) begin
        if (bo_q) begin
          if (wr_data != 8'hFF) tec_q <= 8'd0;
        end else begin
          tec_q   <= wr_data;
          force_q <= (wr_data == 8'hFF);
        end
      end
      if (wr_rec && !bo_q) rec_q <= wr_data;
      if (wr_ewl) ewl_q <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rm_q <= 1'b1;
    else if (enter_bo) rm_q <= 1'b1;
    else if (rm_wr) rm_q <= rm_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= '0;
      idle_q <= 1'b0;
    end else begin
      if (bo_q && rm_q) run_q <= '0;
      else if (bit_stb) run_q <= (!bus_rx || period) ? '0 : run_q + 1'b1;
      if (bit_stb && !bus_rx) idle_q <= 1'b0;
      else if (period) idle_q <= 1'b1;
    end
  end

  assign rst_mode    = rm_q;
  assign err_stat    = es_q;
  assign err_passive = ep_q;
  assign bus_off     = bo_q;
  assign ewi         = ewi_q;
  assign bus_idle    = idle_q;
  assign tec         = tec_q;
  assign rec         = rec_q;
  assign ewl         = ewl_q;

  // R5
  bo_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bo_q) |-> (tec_q == 8'(RECOV_START)) && (rec_q == 8'd0) && rm_q && es_q);
  // R7
  bo_rec_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bo_q |-> rec_q == 8'd0);
  // R6
  bo_tec_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bo_q |-> 32'(tec_q) <= RECOV_START);
  // R6
  bo_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bo_q) |-> (tec_q == 8'd0) && (rec_q == 8'd0) && !es_q && !ep_q);
  // R4
  ewi_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ewi_q |-> $past(ewi_en));
  // R10
  held_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rm_q && $past(rm_q)) |-> ($stable(es_q) && $stable(ep_q)));
endmodule

// File: tb/tb_can_fault_confine.sv
module tb_can_fault_confine;
  logic clk = 1'b0, rst_n = 1'b0;
  logic tec_up = 0, tec_dn = 0, rec_up = 0, rec_dn = 0;
  logic [3:0] tec_up_amt = 0, rec_up_amt = 0;
  logic bit_stb = 0, bus_rx = 1, rm_wr = 0, rm_val = 0, ewi_en = 1;
  logic wr_tec = 0, wr_rec = 0, wr_ewl = 0;
  logic [7:0] wr_data = 0;
  logic rst_mode, err_stat, err_passive, bus_off, ewi, bus_idle;
  logic [7:0] tec, rec, ewl;
  int tests = 0, fails = 0, ewi_cnt = 0, exp_ewi = 0;
  bit done = 0;

  always #2 clk = ~clk;

  can_fault_confine dut (.*);

  always @(negedge clk) if (ewi) ewi_cnt++;

  task automatic chk(string tag, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic settle(); repeat (3) @(negedge clk); endtask

  task automatic tpulse(bit up, int amt, bit dn);
    @(negedge clk); tec_up = up; tec_up_amt = 4'(amt); tec_dn = dn;
    @(negedge clk); tec_up = 0; tec_dn = 0;
    settle();
  endtask

  task automatic rpulse(bit up, int amt, bit dn);
    @(negedge clk); rec_up = up; rec_up_amt = 4'(amt); rec_dn = dn;
    @(negedge clk); rec_up = 0; rec_dn = 0;
    settle();
  endtask

  task automatic set_rm(bit v);
    @(negedge clk); rm_wr = 1; rm_val = v;
    @(negedge clk); rm_wr = 0;
    settle();
  endtask

  task automatic wr(int which, int d);
    @(negedge clk); wr_data = 8'(d);
    wr_tec = (which == 0); wr_rec = (which == 1); wr_ewl = (which == 2);
    @(negedge clk); wr_tec = 0; wr_rec = 0; wr_ewl = 0;
    settle();
  endtask

  task automatic bits(int n, bit v);
    @(negedge clk); bit_stb = 1; bus_rx = v;
    repeat (n - 1) @(negedge clk);
    @(negedge clk); bit_stb = 0; bus_rx = 1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int e;
    repeat (5) @(negedge clk);
    rst_n = 1;
    settle();
    // R1
    chk("R1 tec", tec, 0); chk("R1 rec", rec, 0); chk("R1 ewl", ewl, 96);
    chk("R1 rst_mode", rst_mode, 1); chk("R1 err_stat", err_stat, 0);
    chk("R1 bus_off", bus_off, 0); chk("R1 idle", bus_idle, 0);
    chk("R1 passive", err_passive, 0);
    // R11
    bits(10, 1); settle(); chk("R11 ten recessive", bus_idle, 0);
    bits(1, 0); bits(10, 1); settle(); chk("R11 restart", bus_idle, 0);
    bits(1, 1); settle(); chk("R11 eleventh", bus_idle, 1);
    bits(1, 0); settle(); chk("R11 dominant", bus_idle, 0);
    // R2 gated in reset mode, R7 write gated in operating mode
    tpulse(1, 8, 0); chk("R2 ignored in reset mode", tec, 0);
    set_rm(0); chk("R12 rst_mode cleared", rst_mode, 0);
    wr(0, 50); chk("R7 tec write in operating", tec, 0);
    wr(1, 50); chk("R7 rec write in operating", rec, 0);
    // R2 R3 R4 sweep
    e = 0;
    for (int i = 0; i < 20; i++) begin
      tpulse(1, 8, 0); e += 8;
      chk("R2 tec up", tec, e);
      chk("R3 err_stat", err_stat, e >= 96);
      chk("R3 passive", err_passive, e >= 128);
    end
    exp_ewi = 1; chk("R4 ewi rise", ewi_cnt, exp_ewi);
    for (int i = 0; i < 70; i++) begin
      tpulse(0, 0, 1); e -= 1;
      chk("R2 tec down", tec, e);
      chk("R3 err_stat down", err_stat, e >= 96);
    end
    exp_ewi = 2; chk("R4 ewi fall", ewi_cnt, exp_ewi);
    tpulse(1, 3, 1); e += 2; chk("R2 up and down", tec, e);
    for (int i = 0; i < 5; i++) begin
      rpulse(1, 4, 0); chk("R2 rec up", rec, 4 * (i + 1));
    end
    for (int i = 0; i < 22; i++) begin
      rpulse(0, 0, 1); chk("R2 rec down floor", rec, (20 - i - 1) < 0 ? 0 : 20 - i - 1);
    end
    rpulse(1, 9, 0);
    // R5 overflow
    while (e + 8 <= 255) begin tpulse(1, 8, 0); e += 8; end
    chk("R5 pre tec", tec, e); chk("R5 pre bus_off", bus_off, 0);
    exp_ewi = ewi_cnt;
    tpulse(1, 8, 0);
    chk("R5 bus_off", bus_off, 1); chk("R5 rst_mode", rst_mode, 1);
    chk("R5 tec", tec, 127); chk("R5 rec", rec, 0);
    chk("R5 err_stat", err_stat, 1); chk("R5 passive", err_passive, 1);
    exp_ewi++; chk("R4 ewi on bus-off", ewi_cnt, exp_ewi);
    wr(1, 40); chk("R7 rec write in bus-off", rec, 0);
    // R6 recovery
    set_rm(0);
    bits(5, 1); bits(1, 0);
    for (int p = 1; p <= 127; p++) begin
      bits(11, 1); settle();
      chk("R6 countdown", tec, 127 - p);
      if (p == 3) begin bits(10, 1); bits(1, 0); settle(); chk("R6 dominant restart", tec, 124); end
    end
    chk("R6 still off", bus_off, 1);
    bits(10, 1); settle(); chk("R6 partial period", bus_off, 1);
    bits(1, 1); settle();
    chk("R6 bus on", bus_off, 0); chk("R6 tec", tec, 0); chk("R6 rec", rec, 0);
    chk("R6 err_stat", err_stat, 0); chk("R6 passive", err_passive, 0);
    exp_ewi++; chk("R4 ewi on recovery", ewi_cnt, exp_ewi);
    // R10 held status
    set_rm(1); wr(0, 100);
    chk("R7 tec write in reset mode", tec, 100);
    chk("R10 held", err_stat, 0); chk("R10 held passive", err_passive, 0);
    set_rm(0); chk("R10 released", err_stat, 1);
    exp_ewi++; chk("R4 ewi after release", ewi_cnt, exp_ewi);
    // R8 forced bus-off
    set_rm(1); wr(0, 255);
    chk("R8 tec 255", tec, 255); chk("R8 not yet", bus_off, 0);
    set_rm(0);
    chk("R8 bus_off", bus_off, 1); chk("R8 tec", tec, 127); chk("R8 rst_mode", rst_mode, 1);
    exp_ewi++; chk("R4 ewi forced", ewi_cnt, exp_ewi);
    // R9 short recovery
    wr(0, 20); chk("R9 tec zero", tec, 0); chk("R9 still off", bus_off, 1);
    set_rm(0);
    bits(10, 1); settle(); chk("R9 ten bits", bus_off, 1);
    bits(1, 1); settle(); chk("R9 bus on", bus_off, 0);
    exp_ewi++; chk("R4 ewi short", ewi_cnt, exp_ewi);
    // R7 limit write, R4 disabled
    set_rm(1); wr(2, 32); chk("R7 ewl", ewl, 32);
    set_rm(0); ewi_en = 0;
    for (int i = 0; i < 4; i++) tpulse(1, 8, 0);
    chk("R3 new limit", err_stat, 1);
    chk("R4 no ewi when disabled", ewi_cnt, exp_ewi);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule